// File: doc/BRIEF.md
# Ethernet receive status interrupt unit

This unit sits next to an Ethernet MAC receiver and judges every incoming frame. It watches the frame boundaries, the count of received bytes, the CRC result reported at end of frame and any receive FIFO overflow. When a frame ends, the unit either accepts or drops it and pulses one of two verdict outputs. It also records sticky status bits that software reads through a small register port.

Software clears status bits by writing ones to the status address. It chooses which bits raise the single receive interrupt through an enable register. A policy register lets software keep oversize frames or frames with a bad CRC. When a policy bit is set, the matching frame is treated as good and its error flag stays clear.

Top module: `rx_stat_irq`

## Requirements
- R1: One cycle after the cycle in which `eof_i` is high, exactly one of `frm_ok_o` and `frm_bad_o` pulses for one cycle. Status bit 4 (receive-good) is set in the same cycle, but only when the frame was not dropped for any reason.
- R2: A frame whose byte count is above 1518 is dropped and sets status bit 3 (too-long). A frame of exactly 1518 bytes is good.
- R3: When policy bit 0 (address 2) is 1, an oversize frame is accepted as good and status bit 3 is not set.
- R4: A frame with `crc_err_i` high at end of frame is dropped and sets status bit 1. When policy bit 1 (address 2) is 1, that frame is instead accepted and bit 1 stays clear.
- R5: A `fifo_ovf_i` pulse sets status bit 2 one cycle later. The frame being received is then dropped at its end.
- R6: One frame can set several error bits at once (too-long, overflow and CRC error together).
- R7: A write to address 0 clears every status bit whose data bit is 1. Bits written with 0 keep their value. Bit 0 and bits 7 to 5 of the status always read 0.
- R8: When a hardware set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: The enable register sits at address 1, with bit positions matching the status bits. `irq_o` is a registered OR of status AND enable, so it follows that product one cycle later.
- R10: The byte counter restarts at `sof_i` and saturates instead of wrapping, so a frame far longer than the counter range is still judged too long.
- R11: After reset, status, enable and policy all read 0, and `irq_o`, `frm_ok_o` and `frm_bad_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start-of-frame pulse |
| byte_vld_i | input | 1 | One received byte this cycle |
| eof_i | input | 1 | End-of-frame pulse |
| crc_err_i | input | 1 | CRC check failed, valid with `eof_i` |
| fifo_ovf_i | input | 1 | Receive FIFO overflow pulse |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 status, 1 enable, 2 policy |
| wdata_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data for `addr_i` |
| frm_ok_o | output | 1 | Frame accepted pulse |
| frm_bad_o | output | 1 | Frame dropped pulse |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench targets the length limit on both sides. A 1518-byte frame must be good and a 1519-byte frame must be dropped, so an off-by-one comparison flips one of the two verdicts. A 5000-byte frame checks the counter: one that wraps would see a short length and wrongly accept the frame. The bench also lands a write-one clear in the very cycle a frame ends, and a design that lets the clear win would lose the receive-good event. Finally it combines overflow, CRC error and oversize in one frame, and toggles each policy bit. A design that still raises a flag under an active override, or raises only one flag for several faults, shows the wrong status value.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int STAT_W  = 5;
  localparam int B_GOOD  = 4;
  localparam int B_LONG  = 3;
  localparam int B_OVF   = 2;
  localparam int B_CRC   = 1;
  localparam int POL_W   = 2;
  localparam int P_LONG  = 0;
  localparam int P_CRC   = 1;
  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_EN   = 2'd1,
    A_POL  = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/rx_frame_judge.sv
module rx_frame_judge
  import rx_stat_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sof,
  input  logic              byte_vld,
  input  logic              eof,
  input  logic              crc_err,
  input  logic              fifo_ovf,
  input  logic [POL_W-1:0]  pol,
  output logic [STAT_W-1:0] set_vec,
  output logic              frm_ok,
  output logic              frm_bad
);
  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] LIM     = LEN_W'(MAX_LEN);

  logic [LEN_W-1:0] cnt, cnt_nxt, len_cur;
  logic             cnt_en;
  logic             ovf_seen, ovf_nxt;
  logic             is_long, long_flag, crc_flag, ovf_any, drop;
  logic             ok_nxt, bad_nxt;

  always_comb begin
    len_cur   = (byte_vld && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
    cnt_en    = sof | byte_vld;
    cnt_nxt   = sof ? LEN_W'(byte_vld) : len_cur;
    ovf_any   = ovf_seen | fifo_ovf;
    ovf_nxt   = sof ? fifo_ovf : (eof ? 1'b0 : ovf_any);
    is_long   = len_cur > LIM;
    long_flag = is_long & ~pol[P_LONG];
    crc_flag  = crc_err & ~pol[P_CRC];
    drop      = long_flag | crc_flag | ovf_any;
    ok_nxt    = eof & ~drop;
    bad_nxt   = eof & drop;
    set_vec         = '0;
    set_vec[B_OVF]  = fifo_ovf;
    set_vec[B_LONG] = eof & long_flag;
    set_vec[B_CRC]  = eof & crc_flag;
    set_vec[B_GOOD] = ok_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_seen <= 1'b0;
      frm_ok   <= 1'b0;
      frm_bad  <= 1'b0;
    end else begin
      ovf_seen <= ovf_nxt;
      frm_ok   <= ok_nxt;
      frm_bad  <= bad_nxt;
    end
  end

  assert_one_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frm_ok, frm_bad}));
  assert_verdict_follows_eof_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> (frm_ok | frm_bad));
  assert_long_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && len_cur > LIM && !pol[P_LONG]) |=> frm_bad);
  assert_ovf_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && fifo_ovf) |=> frm_bad);
  assert_cnt_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && byte_vld && !sof) |=> cnt == CNT_MAX);
endmodule

// File: rtl/rx_stat_regs.sv
module rx_stat_regs
  import rx_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DW-1:0]     wdata,
  input  logic [STAT_W-1:0] set_vec,
  output logic [STAT_W-1:0] stat,
  output logic [STAT_W-1:0] en,
  output logic [POL_W-1:0]  pol,
  output logic [DW-1:0]     rd_data
);
  logic              wr_stat, wr_en_reg, wr_pol;
  logic [STAT_W-1:0] clr_vec, stat_nxt;

  always_comb begin
    wr_stat   = wr_en && addr == A_STAT;
    wr_en_reg = wr_en && addr == A_EN;
    wr_pol    = wr_en && addr == A_POL;
    clr_vec   = wr_stat ? wdata[STAT_W-1:0] : '0;
    stat_nxt  = (stat & ~clr_vec) | set_vec;
    case (addr)
      A_STAT:  rd_data = DW'(stat);
      A_EN:    rd_data = DW'(en);
      A_POL:   rd_data = DW'(pol);
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
    end else begin
      stat <= stat_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= '0;
    end else if (wr_en_reg) begin
      en <= wdata[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol <= '0;
    end else if (wr_pol) begin
      pol <= wdata[POL_W-1:0];
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((stat & $past(set_vec)) == $past(set_vec)));
  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ((stat & $past(wdata[STAT_W-1:0]) & ~$past(set_vec)) == '0));
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && set_vec == '0) |=> $stable(stat));
endmodule

// File: rtl/rx_irq_gen.sv
module rx_irq_gen
  import rx_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  input  logic [STAT_W-1:0] en,
  output logic              irq
);
  logic irq_nxt;

  always_comb irq_nxt = |(stat & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_nxt;
    end
  end

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat & en)) |=> irq);
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat & en)) |=> !irq);
endmodule

// File: rtl/rx_stat_irq.sv
module rx_stat_irq
  import rx_stat_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 1518,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sof_i,
  input  logic          byte_vld_i,
  input  logic          eof_i,
  input  logic          crc_err_i,
  input  logic          fifo_ovf_i,
  input  logic          wr_en_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rd_data_o,
  output logic          frm_ok_o,
  output logic          frm_bad_o,
  output logic          irq_o
);
  logic [1:0]        rst_sync;
  logic              rst_l;
  logic [STAT_W-1:0] set_vec, stat, en;
  logic [POL_W-1:0]  pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_l = rst_sync[1];

  rx_frame_judge #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_judge (
    .clk(clk), .rst_n(rst_l), .sof(sof_i), .byte_vld(byte_vld_i),
    .eof(eof_i), .crc_err(crc_err_i), .fifo_ovf(fifo_ovf_i), .pol(pol),
    .set_vec(set_vec), .frm_ok(frm_ok_o), .frm_bad(frm_bad_o)
  );

  rx_stat_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_l), .wr_en(wr_en_i), .addr(addr_i),
    .wdata(wdata_i), .set_vec(set_vec), .stat(stat), .en(en),
    .pol(pol), .rd_data(rd_data_o)
  );

  rx_irq_gen u_irq (
    .clk(clk), .rst_n(rst_l), .stat(stat), .en(en), .irq(irq_o)
  );
endmodule

// File: tb/test_rx_stat_irq.sv
module test_rx_stat_irq;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sof, bv, eof, crc, ovf, wr_en;
  logic [1:0] addr;
  logic [7:0] wdata, rd_data;
  logic       frm_ok, frm_bad, irq;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_stat = 8'h00;
  logic       pol_long = 1'b0;
  logic       pol_crc  = 1'b0;
  logic       exp_q[$];
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_stat_irq i_rx_stat_irq (
    .clk(clk), .rst_n(rst_n), .sof_i(sof), .byte_vld_i(bv), .eof_i(eof),
    .crc_err_i(crc), .fifo_ovf_i(ovf), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_data_o(rd_data), .frm_ok_o(frm_ok),
    .frm_bad_o(frm_bad), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the expected verdict (1 = drop) for each verdict pulse
  always @(negedge clk) begin
    if (rst_n && (frm_ok || frm_bad)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R1 unexpected verdict", {frm_ok, frm_bad}, 0);
      end else begin
        logic e;
        e = exp_q.pop_front();
        chk(frm_bad == e && frm_ok == !e, "R1 verdict", {frm_ok, frm_bad}, {!e, e});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
    addr = 2'd0;
  endtask

  // sends a frame of n bytes; ovf_at < 0 means no overflow; clr is a W1C
  // mask written in the end-of-frame cycle
  task automatic send(input int n, input bit c, input int ovf_at,
                      input logic [7:0] clr, input string req);
    bit lng, ce, ov, drop;
    logic [7:0] setv, got;
    lng  = (n > 1518) && !pol_long;
    ce   = c && !pol_crc;
    ov   = ovf_at >= 0;
    drop = lng | ce | ov;
    setv = {3'b000, !drop, lng, ov, ce, 1'b0};
    exp_q.push_back(drop);
    @(negedge clk);
    sof = 1'b1;
    @(negedge clk);
    sof = 1'b0;
    for (int i = 0; i < n; i++) begin
      bv  = 1'b1;
      ovf = (i == ovf_at);
      @(negedge clk);
    end
    bv = 1'b0; ovf = 1'b0;
    eof = 1'b1; crc = c;
    if (clr != 8'h00) begin
      wr_en = 1'b1; addr = 2'd0; wdata = clr;
    end
    @(negedge clk);
    eof = 1'b0; crc = 1'b0; wr_en = 1'b0; wdata = 8'h00;
    model_stat = (model_stat & ~clr) | setv;
    rd(2'd0, got);
    chk(got == model_stat, req, got, model_stat);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; sof = 0; bv = 0; eof = 0; crc = 0; ovf = 0;
    wr_en = 0; addr = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(2'd0, v); chk(v == 8'h00, "R11 status", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R11 enable", v, 0);
    rd(2'd2, v); chk(v == 8'h00, "R11 policy", v, 0);
    chk({irq, frm_ok, frm_bad} == 3'b000, "R11 outputs", {irq, frm_ok, frm_bad}, 0);

    // R1 good frame
    send(64, 0, -1, 8'h00, "R1 good status");
    wr(2'd0, 8'hFF); model_stat = 8'h00;
    rd(2'd0, v); chk(v == 8'h00, "R7 clear all", v, 0);

    // R2 boundary
    send(1518, 0, -1, 8'h00, "R2 1518 good");
    send(1519, 0, -1, 8'h00, "R2 1519 long");
    // R7 write 0 leaves bits; W1C only bit 3
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk(v == model_stat, "R7 write zero", v, model_stat);
    wr(2'd0, 8'h08); model_stat &= ~8'h08;
    rd(2'd0, v); chk(v == model_stat, "R7 partial clear", v, model_stat);
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R4 CRC error
    send(100, 1, -1, 8'h00, "R4 crc drop");
    // R8 set wins over same-cycle clear, clear of other bit still works
    send(80, 0, -1, 8'h12, "R8 set wins");
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R5 overflow: bit 2 visible mid-frame
    exp_q.push_back(1'b1);
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0; bv = 1'b1; ovf = 1'b1;
    @(negedge clk); ovf = 1'b0;
    rd(2'd0, v); chk(v == 8'h04, "R5 ovf bit mid-frame", v, 8'h04);
    repeat (10) @(negedge clk);
    bv = 1'b0; eof = 1'b1;
    @(negedge clk); eof = 1'b0;
    rd(2'd0, v); chk(v == 8'h04, "R5 ovf frame dropped", v, 8'h04);
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R6 all faults in one frame
    send(1600, 1, 5, 8'h00, "R6 multiple errors");
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R3 / R4 policy overrides
    wr(2'd2, 8'h01); pol_long = 1'b1;
    rd(2'd2, v); chk(v == 8'h01, "R3 policy readback", v, 8'h01);
    send(1600, 0, -1, 8'h00, "R3 accept long");
    wr(2'd2, 8'h02); pol_long = 1'b0; pol_crc = 1'b1;
    send(60, 1, -1, 8'h00, "R4 accept crc");
    wr(2'd2, 8'h00); pol_crc = 1'b0;
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R10 saturation: far beyond counter range still long
    send(5000, 0, -1, 8'h00, "R10 saturated long");
    // R10 counter restarts at sof
    send(20, 0, -1, 8'h00, "R10 restart");
    wr(2'd0, 8'hFF); model_stat = 8'h00;

    // R9 interrupt
    wr(2'd1, 8'h10);
    send(40, 0, -1, 8'h00, "R9 setup");
    chk(irq == 1'b0, "R9 irq lags one cycle", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R9 irq set", irq, 1);
    wr(2'd1, 8'h08);
    chk(irq == 1'b1, "R9 irq before mask", irq, 1);
    @(negedge clk);
    chk(irq == 1'b0, "R9 masked", irq, 0);
    wr(2'd1, 8'h10);
    wr(2'd0, 8'h10); model_stat = 8'h00;
    @(negedge clk);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R1 verdict count", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule